// File: doc/BRIEF.md
# Port-Programmed Buffer-to-Memory DMA Engine

This block moves a run of words from a small device-side buffer, held as a read-only table, into system memory. A processor sets it up through three I/O writes on a port-address bus: one gives the first memory address, one gives the word count, and one starts the move. Once started, the engine asks for the shared system bus. Each word is sent as its own bus tenure: request, grant, enabled drive of a memory-write command with address and data, then acknowledge. After the last word it raises an interrupt and holds it until the processor acknowledges.

Three counters hold the progress. The buffer index counts up from zero and is cleared by the start command. The remaining-words count is loaded by software and counts down. The memory address is loaded by software and counts up. A control state machine sequences them through five states. IDLE accepts programming writes and leaves on a start command (transition GO). REQUEST holds the bus request and leaves when the grant arrives (transition GRANTED). DRIVE enables the bus outputs and leaves on acknowledge: to STEP when words remain (transition MORE) or to INTERRUPT when the count is zero (transition LAST). STEP advances all three counters and returns to REQUEST (transition NEXT). INTERRUPT holds the interrupt and returns to IDLE when it is acknowledged (transition RELEASED).

Top module: `dma_disk_xfer`

## Requirements
- R1: An I/O write (cpu_io_wr high) to port code 1 while IDLE loads the memory-address counter from the low ADDR_W bits of cpu_data. The first word of the next transfer is written to that address.
- R2: An I/O write to port code 2 while IDLE loads the count C from the low bits of cpu_data. A transfer then moves exactly C+1 words, so C=0 moves one word.
- R3: An I/O write to port code 4 while IDLE starts a transfer whatever cpu_data holds. It clears the buffer index, and bus_req is high in the cycle after the write is sampled.
- R4: bus_en rises only in the cycle after bus_gnt was sampled high with bus_req asserted. bus_req stays high for as long as bus_en is high.
- R5: While bus_en is high, bus_cmd equals the memory-write code 3'b101. Word k (k from 0) goes to address (X+k) mod 2^ADDR_W with data equal to the low DATA_W bits of 16'hC0DE XOR (k*16'h0111). Address and data hold steady while bus_en is high.
- R6: A word completes when bus_ack is sampled high during DRIVE. In the next cycle bus_en and bus_req are both low, and the next word is requested afresh.
- R7: While bus_en is low, bus_cmd, bus_addr and bus_data are all zero.
- R8: After the word acknowledged with a zero count, irq goes high in the next cycle and stays high until irq_ack is sampled high. It is low in the cycle after that, and bus_req stays low while irq is high.
- R9: Writes to ports 1, 2 and 4 while a transfer runs or an interrupt is pending have no effect. The running transfer keeps its addresses, data and length, and a start while the interrupt is pending requests no bus.
- R10: After reset, bus_req, bus_en, irq, bus_cmd, bus_addr and bus_data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_io_wr | input | 1 | I/O write strobe from the processor |
| cpu_port | input | PORT_W | Port address of the I/O write |
| cpu_data | input | DATA_W | Data of the I/O write |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_en | output | 1 | Engine is driving the bus |
| bus_ack | input | 1 | Memory has taken the current word |
| bus_cmd | output | CMD_W | Bus command, memory-write code while enabled |
| bus_addr | output | ADDR_W | Memory address of the current word |
| bus_data | output | DATA_W | Buffer word being written |
| irq | output | 1 | Transfer-complete interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The assertions check the per-cycle bus protocol: enable only after a grant, request held under enable, quiet outputs when not enabled, the write code and a steady address while enabled, release after acknowledge, and the interrupt holding and releasing. The bench scenarios show what needs a whole transfer to judge: the word count and its off-by-one, the address sequence across a wrap of the address space, the buffer contents in order, a restarted buffer index on the second run, and programming writes ignored while busy.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQUEST = 3'd1,
        ST_DRIVE   = 3'd2,
        ST_STEP    = 3'd3,
        ST_INTR    = 3'd4
    } dma_state_e;

    localparam logic [2:0] CMD_MEM_WRITE = 3'b101;
    localparam logic [2:0] CMD_NONE      = 3'b000;

    localparam int unsigned PORT_CODE_ADDR  = 1;
    localparam int unsigned PORT_CODE_COUNT = 2;
    localparam int unsigned PORT_CODE_GO    = 4;

    localparam logic [31:0] ROM_SEED = 32'h0000_C0DE;
    localparam logic [31:0] ROM_MULT = 32'h0000_0111;

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode #(
    parameter int PORT_W = 4
) (
    input  logic              io_wr,
    input  logic [PORT_W-1:0] port,
    input  logic              idle,
    output logic              ld_addr,
    output logic              ld_count,
    output logic              go
);
    import dma_pkg::*;

    localparam logic [PORT_W-1:0] P_ADDR  = PORT_W'(PORT_CODE_ADDR);
    localparam logic [PORT_W-1:0] P_COUNT = PORT_W'(PORT_CODE_COUNT);
    localparam logic [PORT_W-1:0] P_GO    = PORT_W'(PORT_CODE_GO);

    logic accept;

    always_comb begin
        accept   = io_wr && idle;
        ld_addr  = accept && (port == P_ADDR);
        ld_count = accept && (port == P_COUNT);
        go       = accept && (port == P_GO);
    end

endmodule

// File: rtl/dma_step_counter.sv
module dma_step_counter #(
    parameter int W          = 4,
    parameter bit COUNT_DOWN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    generate
        if (COUNT_DOWN) begin : g_down
            assign q_next = q - W'(1);
        end else begin : g_up
            assign q_next = q + W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/dma_buf_rom.sv
module dma_buf_rom #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16
) (
    input  logic [$clog2(DEPTH)-1:0] idx,
    output logic [DATA_W-1:0]        word
);
    import dma_pkg::*;

    logic [DATA_W-1:0] table_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            assign table_q[i] = DATA_W'(ROM_SEED ^ (32'(i) * ROM_MULT));
        end
    endgenerate

    assign word = table_q[idx];

endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bus_gnt,
    input  logic bus_ack,
    input  logic irq_ack,
    input  logic count_zero,
    output logic idle,
    output logic buf_clr,
    output logic step,
    output logic bus_req,
    output logic bus_en,
    output logic irq
);
    import dma_pkg::*;

    dma_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go)      state_d = ST_REQUEST;
            ST_REQUEST: if (bus_gnt) state_d = ST_DRIVE;
            ST_DRIVE:   if (bus_ack) state_d = count_zero ? ST_INTR : ST_STEP;
            ST_STEP:                 state_d = ST_REQUEST;
            ST_INTR:    if (irq_ack) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle    = 1'b0;
        buf_clr = 1'b0;
        step    = 1'b0;
        bus_req = 1'b0;
        bus_en  = 1'b0;
        irq     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle    = 1'b1;
                buf_clr = go;
            end
            ST_REQUEST: begin
                bus_req = 1'b1;
            end
            ST_DRIVE: begin
                bus_req = 1'b1;
                bus_en  = 1'b1;
            end
            ST_STEP: begin
                step = 1'b1;
            end
            ST_INTR: begin
                irq = 1'b1;
            end
            default: begin
                idle = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dma_disk_xfer.sv
module dma_disk_xfer #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 16,
    parameter int PORT_W    = 4,
    parameter int CMD_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_io_wr,
    input  logic [PORT_W-1:0] cpu_port,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_en,
    input  logic              bus_ack,
    output logic [CMD_W-1:0]  bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              irq,
    input  logic              irq_ack
);
    import dma_pkg::*;

    localparam int BUF_AW = $clog2(BUF_DEPTH);
    localparam int CNT_W  = BUF_AW;

    logic              idle, buf_clr, step;
    logic              ld_addr, ld_count, go;
    logic [BUF_AW-1:0] buf_idx;
    logic [CNT_W-1:0]  words_left;
    logic [ADDR_W-1:0] mem_addr;
    logic [ADDR_W-1:0] addr_load_val;
    logic [DATA_W-1:0] rom_word;
    logic              count_zero;

    generate
        if (ADDR_W <= DATA_W) begin : g_addr_narrow
            assign addr_load_val = cpu_data[ADDR_W-1:0];
        end else begin : g_addr_wide
            assign addr_load_val = {{(ADDR_W-DATA_W){1'b0}}, cpu_data};
        end
    endgenerate

    assign count_zero = (words_left == '0);

    dma_port_decode #(.PORT_W(PORT_W)) u_decode (
        .io_wr    (cpu_io_wr),
        .port     (cpu_port),
        .idle     (idle),
        .ld_addr  (ld_addr),
        .ld_count (ld_count),
        .go       (go)
    );

    dma_step_counter #(.W(BUF_AW), .COUNT_DOWN(1'b0)) u_buf_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .load     (1'b0),
        .load_val ({BUF_AW{1'b0}}),
        .step     (step),
        .q        (buf_idx)
    );

    dma_step_counter #(.W(CNT_W), .COUNT_DOWN(1'b1)) u_words_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (1'b0),
        .load     (ld_count),
        .load_val (cpu_data[CNT_W-1:0]),
        .step     (step),
        .q        (words_left)
    );

    dma_step_counter #(.W(ADDR_W), .COUNT_DOWN(1'b0)) u_mem_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (1'b0),
        .load     (ld_addr),
        .load_val (addr_load_val),
        .step     (step),
        .q        (mem_addr)
    );

    dma_buf_rom #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_rom (
        .idx  (buf_idx),
        .word (rom_word)
    );

    dma_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .bus_gnt    (bus_gnt),
        .bus_ack    (bus_ack),
        .irq_ack    (irq_ack),
        .count_zero (count_zero),
        .idle       (idle),
        .buf_clr    (buf_clr),
        .step       (step),
        .bus_req    (bus_req),
        .bus_en     (bus_en),
        .irq        (irq)
    );

    always_comb begin
        bus_cmd  = bus_en ? CMD_W'(CMD_MEM_WRITE) : CMD_W'(CMD_NONE);
        bus_addr = bus_en ? mem_addr : '0;
        bus_data = bus_en ? rom_word : '0;
    end

endmodule

// File: rtl/dma_disk_xfer_chk.sv
module dma_disk_xfer_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int PORT_W = 4,
    parameter int CMD_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_io_wr,
    input logic [PORT_W-1:0] cpu_port,
    input logic [DATA_W-1:0] cpu_data,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_en,
    input logic              bus_ack,
    input logic [CMD_W-1:0]  bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              irq,
    input logic              irq_ack
);
    import dma_pkg::*;

    a_r4_enable_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> ($past(bus_gnt) && $past(bus_req)));

    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> bus_req);

    a_r5_write_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> (bus_cmd == CMD_W'(CMD_MEM_WRITE)));

    a_r5_steady_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && $past(bus_en)) |-> ($stable(bus_addr) && $stable(bus_data)));

    a_r6_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_ack) |=> (!bus_en && !bus_req));

    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_cmd == '0 && bus_addr == '0 && bus_data == '0));

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    a_r8_irq_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> !irq);

    a_r8_no_request_in_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!bus_req && !bus_en));

    a_r9_irq_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && cpu_io_wr) |=> !bus_req);

endmodule

bind dma_disk_xfer dma_disk_xfer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PORT_W (PORT_W),
    .CMD_W  (CMD_W)
) u_chk (.*);

// File: tb/dma_disk_xfer_bench.sv
module dma_disk_xfer_bench;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int PORT_W = 4;
    localparam int CMD_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_io_wr = 1'b0;
    logic [PORT_W-1:0] cpu_port = '0;
    logic [DATA_W-1:0] cpu_data = '0;
    logic              bus_req, bus_en, irq;
    logic              bus_gnt = 1'b0;
    logic              bus_ack = 1'b0;
    logic              irq_ack = 1'b0;
    logic [CMD_W-1:0]  bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int gnt_delay = 0;
    int req_cnt   = 0;
    bit ack_follow = 1'b0;
    int err_r4 = 0, err_r5 = 0, err_r6 = 0, err_r7 = 0;
    int log_n = 0;
    logic [ADDR_W-1:0] log_addr [64];
    logic [DATA_W-1:0] log_data [64];

    always #10 clk = ~clk;

    dma_disk_xfer u_dma_disk_xfer (
        .clk, .rst_n, .cpu_io_wr, .cpu_port, .cpu_data,
        .bus_req, .bus_gnt, .bus_en, .bus_ack,
        .bus_cmd, .bus_addr, .bus_data, .irq, .irq_ack
    );

    function automatic logic [DATA_W-1:0] exp_word(int k);
        return DATA_W'(16'hC0DE ^ (16'(k) * 16'h0111));
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory and arbiter model, acting on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_gnt = 1'b0; bus_ack = 1'b0; req_cnt = 0; ack_follow = 1'b0;
            end else begin
                if (ack_follow) begin
                    if (bus_en || bus_req) err_r6++;
                    ack_follow = 1'b0;
                end
                if (!bus_en && (bus_cmd != '0 || bus_addr != '0 || bus_data != '0)) err_r7++;
                if (bus_en && !bus_gnt) err_r4++;
                if (bus_en && !bus_ack) begin
                    if (bus_cmd != 3'b101) err_r5++;
                    if (log_n < 64) begin
                        log_addr[log_n] = bus_addr;
                        log_data[log_n] = bus_data;
                    end
                    log_n++;
                    bus_ack = 1'b1;
                    ack_follow = 1'b1;
                end else begin
                    bus_ack = 1'b0;
                end
                if (bus_req && !bus_en) begin
                    if (req_cnt >= gnt_delay) bus_gnt = 1'b1;
                    else req_cnt++;
                end else if (!bus_req) begin
                    bus_gnt = 1'b0;
                    req_cnt = 0;
                end
            end
        end
    end

    task automatic io_write(input int port, input logic [DATA_W-1:0] data);
        @(negedge clk);
        cpu_io_wr = 1'b1;
        cpu_port  = PORT_W'(port);
        cpu_data  = data;
        @(negedge clk);
        cpu_io_wr = 1'b0;
        cpu_port  = '0;
        cpu_data  = '0;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq == 1'b0, "R8 irq low after acknowledge", irq, 0);
    endtask

    task automatic check_log(input logic [ADDR_W-1:0] x, input int count, input string tag);
        check(log_n == count + 1, {tag, " R2 word total"}, log_n, count + 1);
        for (int k = 0; k < log_n && k < 64; k++) begin
            check(log_addr[k] == ADDR_W'(x + k), {tag, " R1 R5 address"}, log_addr[k], ADDR_W'(x + k));
            check(log_data[k] == exp_word(k), {tag, " R5 data"}, log_data[k], exp_word(k));
        end
        check(err_r4 == 0, {tag, " R4 enable without grant"}, err_r4, 0);
        check(err_r5 == 0, {tag, " R5 write code"}, err_r5, 0);
        check(err_r6 == 0, {tag, " R6 release after ack"}, err_r6, 0);
        check(err_r7 == 0, {tag, " R7 quiet bus"}, err_r7, 0);
    endtask

    task automatic run_xfer(input logic [ADDR_W-1:0] x, input int count, input int gd, input string tag);
        bit seen;
        gnt_delay = gd;
        log_n = 0;
        io_write(1, DATA_W'(x));
        io_write(2, DATA_W'(count));
        io_write(4, 16'hBEEF);
        check(bus_req == 1'b1, {tag, " R3 request after start"}, bus_req, 1);
        wait_irq(seen);
        check(seen, {tag, " R8 irq raised"}, seen, 1);
        check_log(x, count, tag);
        ack_irq();
    endtask

    task automatic t_reset();
        check(bus_req == 1'b0 && bus_en == 1'b0 && irq == 1'b0, "R10 control outputs", {bus_req, bus_en, irq}, 0);
        check(bus_cmd == '0 && bus_addr == '0 && bus_data == '0, "R10 bus outputs", bus_addr, 0);
    endtask

    task automatic t_busy_writes();
        bit seen;
        gnt_delay = 15;
        log_n = 0;
        io_write(1, 16'h0200);
        io_write(2, 16'd2);
        io_write(4, 16'h0000);
        io_write(1, 16'h7777);
        io_write(2, 16'd9);
        io_write(4, 16'h0000);
        wait_irq(seen);
        check(seen, "R9 irq raised", seen, 1);
        check_log(16'h0200, 2, "busy");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(irq == 1'b1, "R8 irq held without ack", irq, 1);
        end
        io_write(4, 16'h0000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(bus_req == 1'b0, "R9 start while irq pending", bus_req, 0);
        end
        ack_irq();
        gnt_delay = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_xfer(16'h0040, 3, 0, "basic");
        run_xfer(16'h1000, 0, 0, "single");
        run_xfer(16'h0300, 5, 6, "slow_grant");
        run_xfer(16'hFFFE, 2, 1, "wrap");
        run_xfer(16'h0800, 15, 0, "full_buffer");
        t_busy_writes();
        run_xfer(16'h0A00, 1, 2, "restart");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule